// File: doc/BRIEF.md
# Polled Serial Transceiver with Fractional Baud Slots

This block is a polled serial transceiver with a small register interface. Software sets the framing, the direction enables, an integer divisor and a 16-bit slot mask. It then moves bytes one at a time. It writes a byte to the transmit holding register to send it, and it polls the status register to learn when a received byte can be collected. The framing is fixed at 8 data bits, no parity and one stop bit. There is no FIFO, no interrupt and no flow control.

The baud generator counts sixteenths of a bit. Each sixteenth lasts divisor+1 clocks. A sixteenth whose index matches a set bit in the slot mask lasts one clock longer. This gives a bit time between two integer multiples of 16, so the line rate can be set more finely than a plain divisor allows. The transmitter and the receiver each have their own generator. The receiver restarts its generator on every start edge, so its sampling points stay locked to the incoming frame.

Top module: `uart_frac`

## Requirements
- R1: After reset, the status register (address 2) reads 0x0002, `txd` is high, and the line-control, mode, divisor and slot-mask registers all read 0.
- R2: The following registers read back what was written: line control at address 0 (6 bits, where 3 means 8N1), mode at address 1 (4 bits), divisor at address 5 (DIV_W bits) and slot mask at address 6 (16 bits). Framing stays 8N1 whatever the line-control value.
- R3: A sixteenth-bit tick spans divisor+1 clocks, plus one clock when slot-mask bit [k] is 1, where k is the current index. The index runs 0 to 15 within every bit and restarts at each frame. Every bit therefore lasts 16*(divisor+1)+popcount(mask) clocks.
- R4: A transmitted frame is a low start bit, then 8 data bits LSB first, then a high stop bit. `txd` is high when idle.
- R5: Status bit 1 is 1 exactly when the transmit holding register (address 3) is empty. A write clears it. It sets again when the byte moves into the shifter. A byte written while a frame is being sent waits until that frame ends and is then sent unchanged.
- R6: Mode bits [3:2] control the transmitter and bits [1:0] control the receiver. The value 01 enables polled operation, so a mode of 5 enables both directions. With the transmitter disabled, a written byte is held and `txd` stays high. With the receiver disabled, `rxd` is ignored.
- R7: The receiver starts on a falling edge of `rxd` and re-checks the line after 8 ticks. If the line is high at that point, the edge is dropped as a glitch. Otherwise the receiver samples each data bit 16 ticks apart, LSB first. When the stop bit is high, the byte is stored and status bit 0 sets.
- R8: Reading address 4 returns the stored byte in bits [7:0] and clears status bits 0 and 2.
- R9: When a byte arrives while status bit 0 is still set, the new byte replaces the old one and status bit 2 (overrun) sets.
- R10: A frame whose stop bit is sampled low is discarded. The buffer and the status are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (read side effects) |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The embedded properties assume that `rd_en` is asserted only with a stable `addr` for one cycle per access. They also assume that the divisor and slot mask are not rewritten while a frame is in flight. The bench changes the configuration only while both lines are idle. It drives `rxd` with bit times computed from the same divisor and mask that are programmed into the block. The bench applies every register access for a single cycle at the falling clock edge, so the read side effects land once per access.

// File: rtl/uart_frac.sv
module uart_frac #(
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  input  logic        rxd,
  output logic        txd
);
  localparam logic [2:0] A_LINE = 3'd0, A_MODE = 3'd1, A_STAT = 3'd2,
                         A_THR = 3'd3, A_RBR = 3'd4, A_DIV = 3'd5, A_SLOT = 3'd6;
  localparam int CW = DIV_W + 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  logic [5:0]       line_q;
  logic [3:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [15:0]      slot_q;

  wire tx_on  = mode_q[3:2] == 2'b01;
  wire rx_on  = mode_q[1:0] == 2'b01;
  wire wr_thr = wr_en && addr == A_THR;
  wire rd_rbr = rd_en && addr == A_RBR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_q <= '0; mode_q <= '0; div_q <= '0; slot_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_LINE: line_q <= wr_data[5:0];
        A_MODE: mode_q <= wr_data[3:0];
        A_DIV:  div_q  <= wr_data[DIV_W-1:0];
        A_SLOT: slot_q <= wr_data;
        default: ;
      endcase
    end

  // transmit side
  logic [7:0]    thr_q, tx_sh;
  logic          thr_full, tx_busy;
  logic [3:0]    tx_bit, tx_idx;
  logic [CW-1:0] tx_cnt;

  wire [CW-1:0] tx_lim  = {1'b0, div_q} + CW'(slot_q[tx_idx]);
  wire          tx_tick = tx_busy && tx_cnt >= tx_lim;
  wire          tx_load = thr_full && !tx_busy && tx_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr_q <= '0; thr_full <= 1'b0;
    end else if (wr_thr) begin
      thr_q <= wr_data[7:0]; thr_full <= 1'b1;
    end else if (tx_load)
      thr_full <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '0; tx_bit <= '0; tx_idx <= '0;
      tx_cnt <= '0; txd <= 1'b1;
    end else if (tx_load) begin
      tx_busy <= 1'b1; tx_sh <= thr_q; tx_bit <= '0; tx_idx <= '0;
      tx_cnt <= '0; txd <= 1'b0;
    end else if (tx_tick) begin
      tx_cnt <= '0;
      tx_idx <= tx_idx + 4'd1;
      if (tx_idx == 4'd15) begin
        if (tx_bit == 4'd9) begin
          tx_busy <= 1'b0;
        end else begin
          tx_bit <= tx_bit + 4'd1;
          if (tx_bit < 4'd8) begin
            txd   <= tx_sh[0];
            tx_sh <= tx_sh >> 1;
          end else
            txd <= 1'b1;
        end
      end
    end else if (tx_busy)
      tx_cnt <= tx_cnt + CW'(1);

  // receive side
  rx_st_t        rx_st;
  logic [2:0]    rx_s;
  logic [7:0]    rx_sh, rbr_q;
  logic [2:0]    rx_n;
  logic [3:0]    rx_idx;
  logic [CW-1:0] rx_cnt;
  logic          rx_avail, rx_ovr;

  wire          rx_line = rx_s[1];
  wire          rx_fall = rx_s[2] && !rx_s[1];
  wire [CW-1:0] rx_lim  = {1'b0, div_q} + CW'(slot_q[rx_idx]);
  wire          rx_tick = rx_st != RX_IDLE && rx_cnt >= rx_lim;
  wire          rx_mid  = rx_tick && rx_idx == 4'd7;
  wire          rx_done = rx_st == RX_STOP && rx_mid && rx_line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_s <= 3'b111;
    else        rx_s <= {rx_s[1:0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_sh <= '0; rx_n <= '0; rx_idx <= '0; rx_cnt <= '0;
    end else if (!rx_on) begin
      rx_st <= RX_IDLE;
    end else if (rx_st == RX_IDLE) begin
      if (rx_fall) begin
        rx_st <= RX_START; rx_idx <= '0; rx_cnt <= '0;
      end
    end else if (rx_tick) begin
      rx_cnt <= '0;
      rx_idx <= rx_idx + 4'd1;
      if (rx_mid)
        case (rx_st)
          RX_START: if (!rx_line) begin rx_st <= RX_DATA; rx_n <= '0; end
                    else rx_st <= RX_IDLE;
          RX_DATA: begin
            rx_sh <= {rx_line, rx_sh[7:1]};
            rx_n  <= rx_n + 3'd1;
            if (rx_n == 3'd7) rx_st <= RX_STOP;
          end
          default: rx_st <= RX_IDLE;
        endcase
    end else
      rx_cnt <= rx_cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbr_q <= '0; rx_avail <= 1'b0; rx_ovr <= 1'b0;
    end else if (rx_done) begin
      rbr_q    <= rx_sh;
      rx_avail <= 1'b1;
      rx_ovr   <= !rd_rbr && (rx_avail || rx_ovr);
    end else if (rd_rbr) begin
      rx_avail <= 1'b0; rx_ovr <= 1'b0;
    end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_LINE: rd_data = {10'd0, line_q};
      A_MODE: rd_data = {12'd0, mode_q};
      A_STAT: rd_data = {13'd0, rx_ovr, !thr_full, rx_avail};
      A_RBR:  rd_data = {8'd0, rbr_q};
      A_DIV:  rd_data = 16'(div_q);
      A_SLOT: rd_data = slot_q;
      default: rd_data = '0;
    endcase
  end

  // R4
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_busy && !txd);
  // R4
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R3
  tx_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_tick && !tx_load) |=> $stable(tx_idx));
  // R8
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rbr && !rx_done) |=> !rx_avail && !rx_ovr);
  // R9
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_avail && !rd_rbr) |=> rx_ovr && rx_avail);
  // R6
  rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> rx_st == RX_IDLE);
endmodule

// File: tb/uart_frac_tb.sv
module uart_frac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rxd = 1'b1;
  logic        txd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_frac u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rxd(rxd), .txd(txd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk); addr = 3'd4; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] b, input int bl, input logic stopv);
    @(negedge clk); rxd = 1'b0;
    repeat (bl - 1) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); rxd = b[k];
      repeat (bl - 1) @(negedge clk);
    end
    @(negedge clk); rxd = stopv;
    repeat (bl - 1) @(negedge clk);
    @(negedge clk); rxd = 1'b1;
    repeat (bl) @(negedge clk);
  endtask

  task automatic tx_grab(input int bl, output logic [7:0] b, output int slen, output logic stopv);
    int n;
    bit run;
    n = 0;
    while (txd !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    n = 0;
    while (txd !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
    slen = 0; run = 1'b1; b = '0; stopv = 1'b0;
    for (int i = 0; i < 10 * bl; i++) begin
      if (run && txd == 1'b0) slen++; else run = 1'b0;
      for (int k = 0; k < 8; k++)
        if (i == bl * (k + 1) + bl / 2) b[k] = txd;
      if (i == 9 * bl + bl / 2) stopv = txd;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    peek(3'd2, d); chk(d == 16'h0002, "R1 status", d, 16'h0002);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    peek(3'd0, d); chk(d == 0, "R1 line ctl", d, 0);
    peek(3'd5, d); chk(d == 0, "R1 divisor", d, 0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr_reg(3'd0, 16'h0003); wr_reg(3'd1, 16'h0005);
    wr_reg(3'd5, 16'd34);   wr_reg(3'd6, 16'hDDDD);
    peek(3'd0, d); chk(d == 16'h0003, "R2 line ctl", d, 3);
    peek(3'd1, d); chk(d == 16'h0005, "R2 mode", d, 5);
    peek(3'd5, d); chk(d == 16'd34, "R2 divisor", d, 34);
    peek(3'd6, d); chk(d == 16'hDDDD, "R2 slot mask", d, 16'hDDDD);
    wr_reg(3'd5, 16'd3); wr_reg(3'd6, 16'h0000);
  endtask

  task automatic t_tx_plain;
    logic [7:0] b; int sl; logic sv;
    wr_reg(3'd3, 16'h00A5);
    tx_grab(64, b, sl, sv);
    chk(b == 8'hA5, "R4 tx byte", b, 8'hA5);
    chk(sl == 64, "R3 bit length integer", sl, 64);
    chk(sv == 1'b1, "R4 stop bit", sv, 1);
  endtask

  task automatic t_tx_frac;
    logic [7:0] b; int sl; logic sv;
    wr_reg(3'd6, 16'hDDDD);
    wr_reg(3'd3, 16'h00A5);
    tx_grab(76, b, sl, sv);
    chk(sl == 76, "R3 bit length fractional", sl, 76);
    chk(b == 8'hA5, "R3 tx byte fractional", b, 8'hA5);
    wr_reg(3'd6, 16'h0000);
  endtask

  task automatic t_thr;
    logic [15:0] d; logic [7:0] b; int sl; logic sv;
    wr_reg(3'd3, 16'h00FF);
    wr_reg(3'd3, 16'h0022);
    peek(3'd2, d); chk(d[1] == 1'b0, "R5 held byte waits", d[1], 0);
    tx_grab(64, b, sl, sv);
    chk(b == 8'h22, "R5 queued byte sent", b, 8'h22);
    peek(3'd2, d); chk(d[1] == 1'b1, "R5 empty after handoff", d[1], 1);
  endtask

  task automatic t_tx_off;
    logic [15:0] d; logic [7:0] b; int sl; logic sv; int lows;
    wr_reg(3'd1, 16'h0001);
    wr_reg(3'd3, 16'h005A);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk(lows == 0, "R6 tx disabled line high", lows, 0);
    peek(3'd2, d); chk(d[1] == 1'b0, "R6 tx disabled byte held", d[1], 0);
    wr_reg(3'd1, 16'h0005);
    tx_grab(64, b, sl, sv);
    chk(b == 8'h5A, "R6 held byte sent on enable", b, 8'h5A);
  endtask

  task automatic t_rx_basic;
    logic [15:0] d;
    rx_frame(8'h3C, 64, 1'b1);
    peek(3'd2, d); chk(d == 16'h0003, "R7 byte available", d, 3);
    pop(d); chk(d == 16'h003C, "R8 rx data", d, 16'h3C);
    peek(3'd2, d); chk(d == 16'h0002, "R8 read clears", d, 2);
  endtask

  task automatic t_rx_overrun;
    logic [15:0] d;
    rx_frame(8'h81, 64, 1'b1);
    rx_frame(8'h7E, 64, 1'b1);
    peek(3'd2, d); chk(d == 16'h0007, "R9 overrun flag", d, 7);
    pop(d); chk(d == 16'h007E, "R9 newest kept", d, 16'h7E);
    peek(3'd2, d); chk(d == 16'h0002, "R8 overrun cleared", d, 2);
  endtask

  task automatic t_rx_badstop;
    logic [15:0] d;
    rx_frame(8'h55, 64, 1'b0);
    peek(3'd2, d); chk(d == 16'h0002, "R10 bad stop discarded", d, 2);
  endtask

  task automatic t_glitch;
    logic [15:0] d;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * 64) @(negedge clk);
    peek(3'd2, d); chk(d == 16'h0002, "R7 glitch rejected", d, 2);
  endtask

  task automatic t_rx_off;
    logic [15:0] d;
    wr_reg(3'd1, 16'h0004);
    rx_frame(8'h99, 64, 1'b1);
    peek(3'd2, d); chk(d == 16'h0002, "R6 rx disabled ignores line", d, 2);
    wr_reg(3'd1, 16'h0005);
  endtask

  task automatic t_rx_frac;
    logic [15:0] d;
    wr_reg(3'd6, 16'hDDDD);
    rx_frame(8'hC3, 76, 1'b1);
    pop(d); chk(d == 16'h00C3, "R3 rx fractional", d, 16'hC3);
    wr_reg(3'd6, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_tx_plain;
    t_tx_frac;
    t_thr;
    t_tx_off;
    t_rx_basic;
    t_rx_overrun;
    t_rx_badstop;
    t_glitch;
    t_rx_off;
    t_rx_frac;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule